// File: doc/BRIEF.md
# Lane Calibration and Pseudo-Random Test Pattern Source

This block sits just ahead of a multi-lane serializer and decides, frame by frame, what each lane carries. Normally every data lane forwards its 7-bit slice of the parallel input word, and the clock lane sends its usual 7-bit clock shape. Two control inputs change this.

Pulling the active-low calibration request low starts a calibration pattern. The parallel input is no longer taken, and every data lane sends a fixed 7-bit calibration frame. The clock lane switches to a different 7-bit shape so that the far end can tell calibration is under way. A saturating cycle counter reports when the request has been held long enough for the far end to finish.

With calibration idle, raising the test enable replaces the lane data with a pseudo-random bit stream. A width select picks the 15-bit or the 23-bit generator. Calibration overrides the test stream, and the test stream overrides normal data. Every output is registered, so a change at the inputs shows at the outputs one clock later.

Top module: `lane_pattern_src`

## Requirements
- R1: While reset is asserted, every lane frame is 0, the clock-lane frame is 1111000 (bit 6 first), and both the ignore flag and the calibration-done flag are low.
- R2: With the calibration request high and the test enable low, each lane frame equals its 7-bit slice of the input word one clock later (lane k uses bits 7k+6..7k). The clock-lane frame is 1111000 and the ignore flag is low.
- R3: With the calibration request low, every data-lane frame is 1111000 one clock later, whatever the input word is.
- R4: With the calibration request low, the clock-lane frame is 1111100 one clock later.
- R5: Calibration takes priority over the test stream. With the request low, the test enable and width select have no effect on the outputs, and the ignore flag is high.
- R6: The calibration-done flag goes high after 4096 consecutive clocks with the request low and not after 4095. It stays high while the request is held.
- R7: Releasing the request clears the count at once. A new request needs a full 4096 further clocks before the done flag is raised.
- R8: With the test enable high and the width select low, all lanes carry the same 7-bit chunk of the x^15+x^14+1 sequence on each clock. Each chunk holds the next 7 generated bits, earliest in bit 6, and the ignore flag is high. The feedback bit is the XOR of the two oldest tapped stages.
- R9: With the test enable and the width select both high, the lanes carry the x^23+x^18+1 sequence in the same chunked form.
- R10: With the test enable low, toggling the width select has no effect; the lanes keep forwarding the input data.
- R11: The generator state is all ones after reset and is reloaded to all ones on every clock that is not in test mode. Each new test run therefore starts from the same first chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_req_n | input | 1 | Calibration request, active low |
| test_en | input | 1 | Pseudo-random test stream enable |
| test_long | input | 1 | Width select: 1 picks the 23-bit generator, 0 the 15-bit one |
| lane_data_i | input | LANES*7 | Parallel input word, 7 bits per lane |
| lane_frame_o | output | LANES*7 | Registered per-lane frames |
| clk_frame_o | output | 7 | Registered clock-lane frame |
| data_ignored_o | output | 1 | High while the lane frames do not come from the input word |
| cal_done_o | output | 1 | Calibration held long enough |

## Verification
The bench checks the calibration count at exactly 4095 and 4096 held clocks. An off-by-one counter would raise the done flag a cycle early or late. A short release in the middle of a long request is also tested: a counter that pauses instead of clearing would report done far too soon. Test mode is entered with calibration also requested, which exposes any reversed priority, and is then re-entered after calibration, where a generator that is not reseeded would resume mid-sequence. Toggling the width select with the test stream off catches a select that leaks into the pass-through path.

// File: rtl/lps_pkg.sv
`timescale 1ns/1ps
package lps_pkg;
  localparam int FRAME_W = 7;
  // data lanes during calibration, clock lane in normal operation
  localparam logic [FRAME_W-1:0] PAT_BASE    = 7'b1111000;
  // clock lane during calibration
  localparam logic [FRAME_W-1:0] PAT_CAL_CLK = 7'b1111100;
  typedef enum logic [1:0] {SRC_DATA, SRC_TEST, SRC_CAL} src_e;
endpackage

// File: rtl/lps_prbs.sv
`timescale 1ns/1ps
module lps_prbs #(
  parameter int LONG_W    = 23,
  parameter int LONG_TAP  = 18,
  parameter int SHORT_W   = 15,
  parameter int SHORT_TAP = 14,
  parameter int STEP      = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            long_sel,
  output logic [STEP-1:0] chunk
);
  localparam logic [LONG_W-1:0] SEED = '1;

  logic [LONG_W-1:0] state_q, state_d, walk;
  logic              fb;

  // unroll STEP shifts; earliest generated bit lands in chunk MSB
  always_comb begin
    walk  = state_q;
    chunk = '0;
    fb    = 1'b0;
    for (int k = 0; k < STEP; k++) begin
      if (long_sel) fb = walk[LONG_W-1] ^ walk[LONG_TAP-1];
      else          fb = walk[SHORT_W-1] ^ walk[SHORT_TAP-1];
      walk = {walk[LONG_W-2:0], fb};
      chunk[STEP-1-k] = fb;
    end
    state_d = run ? walk : SEED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  // R8: generator never collapses into the all-zero lock-up state
  a_r8_state_live: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  // R11: outside test mode the state is back at the seed next cycle
  a_r11_reseed: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> state_q == SEED);
endmodule

// File: rtl/lps_caltimer.sv
`timescale 1ns/1ps
module lps_caltimer #(
  parameter int CAL_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic done
);
  localparam int CW = $clog2(CAL_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(CAL_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = !active || (cnt_q != LIMIT);
    if (!active) cnt_d = '0;
    else         cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == LIMIT);

  // R7: release clears the status on the next edge
  a_r7_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !done);
  // R6: done only follows a held request
  a_r6_done_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(active));
  // R6: saturation keeps done high while still held
  a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (done && active) |=> done);
endmodule

// File: rtl/lane_pattern_src.sv
`timescale 1ns/1ps
module lane_pattern_src
  import lps_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int CAL_CYCLES = 4096
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cal_req_n,
  input  logic                     test_en,
  input  logic                     test_long,
  input  logic [LANES*FRAME_W-1:0] lane_data_i,
  output logic [LANES*FRAME_W-1:0] lane_frame_o,
  output logic [FRAME_W-1:0]       clk_frame_o,
  output logic                     data_ignored_o,
  output logic                     cal_done_o
);
  localparam int BUS_W = LANES * FRAME_W;

  src_e               src;
  logic [FRAME_W-1:0] prbs_chunk;
  logic [BUS_W-1:0]   lanes_d;
  logic [FRAME_W-1:0] clk_d;
  logic               ign_d;

  // priority: calibration, then test stream, then data
  always_comb begin
    if (!cal_req_n)   src = SRC_CAL;
    else if (test_en) src = SRC_TEST;
    else              src = SRC_DATA;
  end

  lps_prbs #(.STEP(FRAME_W)) u_prbs (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (src == SRC_TEST),
    .long_sel (test_long),
    .chunk    (prbs_chunk)
  );

  lps_caltimer #(.CAL_CYCLES(CAL_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (!cal_req_n),
    .done   (cal_done_o)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      unique case (src)
        SRC_CAL:  lanes_d[g*FRAME_W +: FRAME_W] = PAT_BASE;
        SRC_TEST: lanes_d[g*FRAME_W +: FRAME_W] = prbs_chunk;
        default:  lanes_d[g*FRAME_W +: FRAME_W] = lane_data_i[g*FRAME_W +: FRAME_W];
      endcase
    end
  end

  always_comb begin
    clk_d = (src == SRC_CAL) ? PAT_CAL_CLK : PAT_BASE;
    ign_d = (src != SRC_DATA);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_frame_o   <= '0;
      clk_frame_o    <= PAT_BASE;
      data_ignored_o <= 1'b0;
    end else begin
      lane_frame_o   <= lanes_d;
      clk_frame_o    <= clk_d;
      data_ignored_o <= ign_d;
    end
  end

  a_r3_cal_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_req_n |=> lane_frame_o == {LANES{PAT_BASE}});
  a_r4_cal_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_req_n |=> clk_frame_o == PAT_CAL_CLK);
  a_r5_flag_in_cal: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_req_n |=> data_ignored_o);
  a_r2_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_req_n && !test_en) |=> (lane_frame_o == $past(lane_data_i)) && !data_ignored_o
                                 && clk_frame_o == PAT_BASE);
  a_r8_lanes_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_req_n && test_en) |=> lane_frame_o == {LANES{lane_frame_o[FRAME_W-1:0]}});
endmodule

// File: tb/tb_lane_pattern_src.sv
`timescale 1ns/1ps
module tb_lane_pattern_src;
  localparam int LANES = 8;
  localparam int BW    = LANES * 7;
  localparam int CAL   = 4096;
  localparam logic [6:0] BASE = 7'b1111000;
  localparam logic [6:0] CCLK = 7'b1111100;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cal_req_n, test_en, test_long;
  logic [BW-1:0] lane_data_i, lane_frame_o;
  logic [6:0]    clk_frame_o;
  logic          data_ignored_o, cal_done_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [22:0] m_state;

  always #5 clk = ~clk;

  lane_pattern_src #(.LANES(LANES), .CAL_CYCLES(CAL)) dut (
    .clk(clk), .rst_n(rst_n), .cal_req_n(cal_req_n), .test_en(test_en),
    .test_long(test_long), .lane_data_i(lane_data_i), .lane_frame_o(lane_frame_o),
    .clk_frame_o(clk_frame_o), .data_ignored_o(data_ignored_o), .cal_done_o(cal_done_o));

  // vector: {cal_req_n, test_en, test_long, data}
  localparam int NV = 14;
  localparam logic [BW+2:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 56'h0123456789ABCD},  // R2
    {1'b1, 1'b0, 1'b1, 56'hFEDCBA98765432},  // R10 select toggled
    {1'b1, 1'b0, 1'b0, 56'h55AA55AA55AA55},  // R10
    {1'b1, 1'b1, 1'b0, 56'h11111111111111},  // R8
    {1'b1, 1'b1, 1'b0, 56'h22222222222222},  // R8
    {1'b1, 1'b1, 1'b0, 56'h33333333333333},  // R8
    {1'b0, 1'b1, 1'b1, 56'h44444444444444},  // R5 cal over test
    {1'b0, 1'b0, 1'b0, 56'h00FF00FF00FF00},  // R3 R4
    {1'b1, 1'b1, 1'b1, 56'h66666666666666},  // R9 from seed
    {1'b1, 1'b1, 1'b1, 56'h77777777777777},  // R9
    {1'b1, 1'b1, 1'b1, 56'h88888888888888},  // R9
    {1'b1, 1'b0, 1'b1, 56'h99999999999999},  // R2
    {1'b1, 1'b1, 1'b0, 56'hAAAAAAAAAAAAAA},  // R11 restart short
    {1'b1, 1'b1, 1'b0, 56'hBBBBBBBBBBBBBB}   // R8
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // next 7 bits of the selected sequence, earliest in bit 6
  function automatic logic [29:0] gen7(input logic [22:0] s, input logic lng);
    logic [6:0] c;
    logic b;
    for (int k = 0; k < 7; k++) begin
      b = lng ? (s[22] ^ s[17]) : (s[14] ^ s[13]);
      s = {s[21:0], b};
      c[6-k] = b;
    end
    return {c, s};
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [BW-1:0] e_lanes;
    logic [6:0]    e_clk;
    logic          e_ign;
    logic [29:0]   g;
    string         tag;
    rst_n = 1'b0; cal_req_n = 1'b1; test_en = 1'b0; test_long = 1'b0;
    lane_data_i = '1;
    m_state = '1;
    repeat (3) @(negedge clk);
    chk("R1 lanes", 64'(lane_frame_o), 64'd0);
    chk("R1 clock", 64'(clk_frame_o), 64'(BASE));
    chk("R1 flags", 64'({data_ignored_o, cal_done_o}), 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {cal_req_n, test_en, test_long, lane_data_i} = VEC[i];
      if (!cal_req_n) begin
        e_lanes = {LANES{BASE}}; e_clk = CCLK; e_ign = 1'b1; m_state = '1; tag = "R3/R5";
      end else if (test_en) begin
        g = gen7(m_state, test_long);
        e_lanes = {LANES{g[29:23]}}; m_state = g[22:0]; e_clk = BASE; e_ign = 1'b1;
        tag = test_long ? "R9/R11" : "R8/R11";
      end else begin
        e_lanes = lane_data_i; e_clk = BASE; e_ign = 1'b0; m_state = '1; tag = "R2/R10";
      end
      @(posedge clk); @(negedge clk);
      chk({tag, " lanes"}, 64'(lane_frame_o), 64'(e_lanes));
      chk((!cal_req_n) ? "R4 clock" : "R2 clock", 64'(clk_frame_o), 64'(e_clk));
      chk({tag, " flag"}, 64'(data_ignored_o), 64'(e_ign));
    end

    // R6: exact count boundary
    cal_req_n = 1'b0; test_en = 1'b0;
    repeat (CAL - 1) @(posedge clk);
    @(negedge clk);
    chk("R6 done at 4095", 64'(cal_done_o), 64'd0);
    @(posedge clk); @(negedge clk);
    chk("R6 done at 4096", 64'(cal_done_o), 64'd1);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R6 held", 64'(cal_done_o), 64'd1);

    // R7: short release restarts the count
    cal_req_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R7 cleared", 64'(cal_done_o), 64'd0);
    cal_req_n = 1'b0;
    repeat (100) @(posedge clk);
    @(negedge clk);
    cal_req_n = 1'b1;
    @(posedge clk); @(negedge clk);
    cal_req_n = 1'b0;
    repeat (CAL - 1) @(posedge clk);
    @(negedge clk);
    chk("R7 no early done", 64'(cal_done_o), 64'd0);
    @(posedge clk); @(negedge clk);
    chk("R7 done after full run", 64'(cal_done_o), 64'd1);
    chk("R3 lanes in long cal", 64'(lane_frame_o), 64'({LANES{BASE}}));

    summary();
  end
endmodule